// File: doc/BRIEF.md
# Load-Use Stall Detector

This block sits beside the decode stage of an in-order five-stage pipeline. Each cycle it checks whether the instruction in decode reads a register that a load, now one stage ahead in execute, will write. The loaded value comes back from memory too late for forwarding to deliver it to that instruction. In that case the block holds the front of the pipeline for one cycle and sends a bubble into the execute stage.

The detector is purely combinational. It compares the two source register indices of the decoding instruction against the destination index of the instruction in execute. A comparison only counts when that instruction is a memory read and its destination is not register 0. On a hit it drops the program-counter write enable and the decode-register write enable, and it raises a bubble select. The surrounding pipeline uses the bubble select to load an all-zero control word into the execute register.

On the following cycle the load has moved on to the memory stage, so the hit clears by itself. A load followed by its consumer therefore takes two cycles in place of one. Every other dependency is left to the forwarding network. The clock and reset inputs serve only the embedded checks.

Top module: `load_use_stall_det`

## Requirements
- R1: When `ex_mem_rd_i` is 1, `ex_rt_i` is nonzero and `ex_rt_i` equals `dec_rs_i`, `pc_we_o` and `dec_we_o` are 0 and `bubble_o` is 1 in the same cycle.
- R2: When `ex_mem_rd_i` is 1, `ex_rt_i` is nonzero and `ex_rt_i` equals `dec_rt_i`, the block stalls as in R1.
- R3: When `ex_mem_rd_i` is 0, no stall is raised, even if the register indices match.
- R4: A load whose destination matches neither decode source raises no stall.
- R5: A load whose destination index is 0 never raises a stall.
- R6: Outside a stall, `pc_we_o` and `dec_we_o` are 1 and `bubble_o` is 0. The two write enables are always equal, and `bubble_o` is always their inverse.
- R7: In a running pipeline, a load immediately followed by a consumer of its result costs exactly one stall cycle.
- R8: A consumer placed two instructions after the load raises no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, used by the embedded checks |
| rst_ni | input | 1 | Active-low asynchronous reset, used by the embedded checks |
| dec_rs_i | input | REG_AW | First source register index of the instruction in decode |
| dec_rt_i | input | REG_AW | Second source register index of the instruction in decode |
| ex_rt_i | input | REG_AW | Destination index of a load that is in execute |
| ex_mem_rd_i | input | 1 | Instruction in execute reads memory |
| pc_we_o | output | 1 | Program counter write enable |
| dec_we_o | output | 1 | Fetch-to-decode register write enable |
| bubble_o | output | 1 | Selects a zero control word into the execute register |

## Verification
On every cycle, the assertions check the stall conditions on each source (R1, R2), the suppression rules for non-loads and for register 0 (R3, R5), and the fixed relation between the three outputs (R6). The bench alone can show the cost in a running pipeline: one bubble for a load followed by its consumer (R7), and none when the consumer comes two slots later (R8). For this, the bench drives the block from a small pipeline model that obeys the block's enables.

// File: rtl/lus_pkg.sv
package lus_pkg;
  typedef struct packed {
    logic pc_we;
    logic dec_we;
    logic bubble;
  } lus_ctrl_t;

  localparam lus_ctrl_t LUS_RUN  = '{pc_we: 1'b1, dec_we: 1'b1, bubble: 1'b0};
  localparam lus_ctrl_t LUS_HOLD = '{pc_we: 1'b0, dec_we: 1'b0, bubble: 1'b1};
endpackage

// File: rtl/lus_src_match.sv
module lus_src_match #(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic          dst_live_i,
  output logic          hit_o
);
  assign hit_o = dst_live_i && (src_i == dst_i);
endmodule

// File: rtl/lus_ctrl.sv
module lus_ctrl
  import lus_pkg::*;
#(
  parameter int unsigned NUM_SRC = 2
) (
  input  logic [NUM_SRC-1:0] hit_i,
  output lus_ctrl_t          ctrl_o
);
  assign ctrl_o = (|hit_i) ? LUS_HOLD : LUS_RUN;
endmodule

// File: rtl/load_use_stall_det.sv
module load_use_stall_det
  import lus_pkg::*;
#(
  parameter int unsigned REG_AW = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] dec_rs_i,
  input  logic [REG_AW-1:0] dec_rt_i,
  input  logic [REG_AW-1:0] ex_rt_i,
  input  logic              ex_mem_rd_i,
  output logic              pc_we_o,
  output logic              dec_we_o,
  output logic              bubble_o
);
  localparam int unsigned NUM_SRC = 2;

  logic [NUM_SRC-1:0][REG_AW-1:0] srcs;
  logic [NUM_SRC-1:0]             hits;
  logic                           load_live;
  lus_ctrl_t                      ctrl;

  assign srcs[0] = dec_rs_i;
  assign srcs[1] = dec_rt_i;

  // register 0 is hardwired, a load into it produces nothing to wait for
  assign load_live = ex_mem_rd_i && (|ex_rt_i);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    lus_src_match #(.AW(REG_AW)) i_match (
      .src_i      (srcs[g]),
      .dst_i      (ex_rt_i),
      .dst_live_i (load_live),
      .hit_o      (hits[g])
    );
  end

  lus_ctrl #(.NUM_SRC(NUM_SRC)) i_ctrl (
    .hit_i  (hits),
    .ctrl_o (ctrl)
  );

  assign pc_we_o  = ctrl.pc_we;
  assign dec_we_o = ctrl.dec_we;
  assign bubble_o = ctrl.bubble;

  AST_RS_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_mem_rd_i && ex_rt_i != '0 && ex_rt_i == dec_rs_i) |-> (!pc_we_o && bubble_o)); // R1
  AST_RT_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_mem_rd_i && ex_rt_i != '0 && ex_rt_i == dec_rt_i) |-> (!pc_we_o && bubble_o)); // R2
  AST_NO_LOAD_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ex_mem_rd_i |-> pc_we_o); // R3
  AST_ZERO_DST_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_rt_i == '0) |-> pc_we_o); // R5
  AST_OUT_COHERENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_we_o == dec_we_o) && (bubble_o == !pc_we_o)); // R6
endmodule

// File: tb/test_load_use_stall_det.sv
module test_load_use_stall_det;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] dec_rs = '0, dec_rt = '0, ex_rt = '0;
  logic          ex_rd = 1'b0;
  logic          pc_we, dec_we, bubble;
  int            n_chk = 0, n_fail = 0;
  bit            done = 1'b0;

  always #10 clk = ~clk;

  load_use_stall_det #(.REG_AW(AW)) i_load_use_stall_det (
    .clk_i(clk), .rst_ni(rst_n), .dec_rs_i(dec_rs), .dec_rt_i(dec_rt),
    .ex_rt_i(ex_rt), .ex_mem_rd_i(ex_rd),
    .pc_we_o(pc_we), .dec_we_o(dec_we), .bubble_o(bubble));

  task automatic check_out(string req, bit exp_stall);
    logic [2:0] act, exp;
    act = {pc_we, dec_we, bubble};
    exp = exp_stall ? 3'b001 : 3'b110;
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {pc_we,dec_we,bubble} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic apply(input logic [AW-1:0] rs, rt, xrt, input logic rd);
    @(negedge clk);
    dec_rs = rs; dec_rt = rt; ex_rt = xrt; ex_rd = rd;
    #2;
  endtask

  task automatic t_reset_state;
    apply('0, '0, '0, 1'b0);
    check_out("R6 reset", 1'b0);
  endtask

  task automatic t_rs_hit;
    apply(5'd2, 5'd5, 5'd2, 1'b1); check_out("R1", 1'b1);
    apply(5'd31, 5'd0, 5'd31, 1'b1); check_out("R1 top index", 1'b1);
  endtask

  task automatic t_rt_hit;
    apply(5'd1, 5'd2, 5'd2, 1'b1); check_out("R2", 1'b1);
    apply(5'd7, 5'd7, 5'd7, 1'b1); check_out("R2 both sources", 1'b1);
  endtask

  task automatic t_no_load;
    apply(5'd2, 5'd2, 5'd2, 1'b0); check_out("R3", 1'b0);
  endtask

  task automatic t_unrelated;
    apply(5'd1, 5'd5, 5'd2, 1'b1); check_out("R4", 1'b0);
    apply(5'd3, 5'd4, 5'd12, 1'b1); check_out("R4 second pattern", 1'b0);
  endtask

  task automatic t_zero_dst;
    apply(5'd0, 5'd0, 5'd0, 1'b1); check_out("R5", 1'b0);
  endtask

  // pipeline model: instr = {is_load, rs, rt}; load writes rt
  task automatic run_stream(string req, input logic [10:0] prog [4], int len, int exp_stalls);
    logic [10:0] ifid, idex;
    int pc, stalls;
    ifid = '0; idex = '0; pc = 0; stalls = 0;
    for (int c = 0; c < len + 3; c++) begin
      apply(ifid[9:5], ifid[4:0], idex[4:0], idex[10]);
      if (bubble) stalls++;
      idex = bubble ? 11'd0 : ifid;
      if (dec_we) ifid = (pc < len) ? prog[pc] : 11'd0;
      if (pc_we) pc++;
    end
    n_chk++;
    if (stalls != exp_stalls) begin
      n_fail++;
      $display("FAIL %s: stall cycles actual=%0d expected=%0d", req, stalls, exp_stalls);
    end
  endtask

  task automatic t_streams;
    logic [10:0] p [4];
    p[0] = {1'b1, 5'd1, 5'd2}; p[1] = {1'b0, 5'd2, 5'd5};
    p[2] = '0; p[3] = '0;
    run_stream("R7 load then consumer", p, 2, 1);
    p[1] = {1'b0, 5'd1, 5'd5}; p[2] = {1'b0, 5'd2, 5'd6};
    run_stream("R8 consumer two later", p, 3, 0);
    p[0] = {1'b1, 5'd1, 5'd0}; p[1] = {1'b0, 5'd0, 5'd0};
    run_stream("R5 stream into reg 0", p, 2, 0);
    p[0] = {1'b1, 5'd1, 5'd2}; p[1] = {1'b1, 5'd2, 5'd3}; p[2] = {1'b0, 5'd3, 5'd3};
    run_stream("R7 chained loads", p, 3, 2);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_rs_hit();
    t_rt_hit();
    t_no_load();
    t_unrelated();
    t_zero_dst();
    t_streams();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule